// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the write-only configuration port of a display driver. A host shares one three-line bus among up to eight such drivers: an active-low enable, a serial clock and a serial data line. Each transfer opens with a designation byte. That byte names a chip and a starting register. Data bytes follow, and each one lands in the next register. A driver only takes part when the chip field matches its strapped 3-bit identity.

The port holds seven registers. Register 0 is a mode byte, and the block brings out each of its bits as its own control output, one of which is a soft reset. The other six are level settings, six to eight bits wide. A data byte is committed only when a further full byte has arrived, so every burst must end with one dummy byte. After power-up the host must set the soft reset and then clear it. Until it does so, the level registers refuse writes. The serial lines are synchronised into the system clock domain, and their edges are detected there.

Top module: `serial_cfg_port`

## Requirements
- R1: After `rst_n` the level outputs are centre 20h, gain BFh, brightness 00h, common 00h, precharge A 00h and precharge B 00h, and every mode output is 0.
- R2: The designation byte is the first byte after enable falls. Bits 6:4 hold the chip identity and bits 2:0 hold the start register; bits 7 and 3 are ignored. A transfer whose chip field differs from `strap_id` changes no output.
- R3: Bits are taken MSB first on rising `cfg_sck` while `cfg_en_n` is low. A data byte is written only once the next full byte has been received, so a designation plus a single data byte writes nothing.
- R4: Successive data bytes in one transfer go to successive registers, starting at the designated one. Register index: 0 mode, 1 centre, 2 gain, 3 brightness, 4 common, 5 precharge A, 6 precharge B.
- R5: Narrow registers keep only the low bits of the data byte: 6 bits for centre, 7 bits for common and both precharge registers.
- R6: The mode byte drives the outputs bit7 `soft_rst`, bit6 `pre_alt`, bit5 `line_inv`, bit4 `strobe_mode`, bit3 `scan_rev`, bit2 `pre_dual`, bit1 `pre_pol` and bit0 `clk_inv`.
- R7: After `rst_n`, registers 1 to 6 ignore writes until register 0 has been written with bit7 set and then written with bit7 clear.
- R8: While `soft_rst` is 1, registers 1 to 6 sit at their R1 values and ignore writes.
- R9: If enable rises in the middle of a byte, the partial bits are dropped. The next transfer starts afresh with a designation byte.
- R10: A start register of 7 writes nothing. The register index stops advancing at 6, so extra bytes all go to register 6.
- R11: Clock edges while `cfg_en_n` is high change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_id | input | 3 | Strapped chip identity |
| cfg_en_n | input | 1 | Serial enable, active low |
| cfg_sck | input | 1 | Serial clock |
| cfg_sdi | input | 1 | Serial data |
| center_lvl | output | 6 | Signal centre setting |
| gain_lvl | output | 8 | Gain setting |
| bright_lvl | output | 8 | Brightness offset setting |
| vcom_lvl | output | 7 | Common voltage setting |
| pre_a_lvl | output | 7 | Precharge level A |
| pre_b_lvl | output | 7 | Precharge level B |
| soft_rst | output | 1 | Mode bit 7, soft reset |
| pre_alt | output | 1 | Mode bit 6 |
| line_inv | output | 1 | Mode bit 5 |
| strobe_mode | output | 1 | Mode bit 4 |
| scan_rev | output | 1 | Mode bit 3 |
| pre_dual | output | 1 | Mode bit 2 |
| pre_pol | output | 1 | Mode bit 1 |
| clk_inv | output | 1 | Mode bit 0 |

## Verification
The assertions assume that the serial lines change slowly compared with `clk`. Each level must last several system cycles, so that the synchroniser sees every serial clock edge exactly once, and data must be stable around the rising edge. The bench keeps every serial half-period at four system cycles and changes data and enable only while the serial clock is low. It also leaves several idle cycles after enable rises, before it looks at the outputs.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_id,
  input  logic       cfg_en_n,
  input  logic       cfg_sck,
  input  logic       cfg_sdi,
  output logic [5:0] center_lvl,
  output logic [7:0] gain_lvl,
  output logic [7:0] bright_lvl,
  output logic [6:0] vcom_lvl,
  output logic [6:0] pre_a_lvl,
  output logic [6:0] pre_b_lvl,
  output logic       soft_rst,
  output logic       pre_alt,
  output logic       line_inv,
  output logic       strobe_mode,
  output logic       scan_rev,
  output logic       pre_dual,
  output logic       pre_pol,
  output logic       clk_inv
);
  localparam logic [2:0] LAST_REG   = 3'd6;
  localparam logic [5:0] CENTER_DEF = 6'h20;
  localparam logic [7:0] GAIN_DEF   = 8'hBF;

  logic [1:0] en_q, sdi_q;
  logic [2:0] sck_q;
  logic [6:0] shift_q;
  logic [2:0] bit_cnt, ptr, pend_a;
  logic [7:0] pend_d, mode_q;
  logic       have_des, sel, pend_v, armed;

  wire       en_low    = !en_q[1];
  wire       sck_rise  = sck_q[1] & !sck_q[2];
  wire [7:0] new_byte  = {shift_q, sdi_q[1]};
  wire       byte_done = en_low & sck_rise & (bit_cnt == 3'd7);
  wire       commit    = byte_done & have_des & sel & pend_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 2'b11;
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      en_q  <= {en_q[0], cfg_en_n};
      sck_q <= {sck_q[1:0], cfg_sck};
      sdi_q <= {sdi_q[0], cfg_sdi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shift_q  <= '0;
      bit_cnt  <= '0;
      have_des <= 1'b0;
      sel      <= 1'b0;
      ptr      <= '0;
      pend_v   <= 1'b0;
      pend_d   <= '0;
      pend_a   <= '0;
    end else if (!en_low) begin
      bit_cnt  <= '0;
      have_des <= 1'b0;
      sel      <= 1'b0;
      pend_v   <= 1'b0;
    end else if (sck_rise) begin
      shift_q <= new_byte[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        if (!have_des) begin
          have_des <= 1'b1;
          sel      <= (new_byte[6:4] == strap_id);
          ptr      <= new_byte[2:0];
        end else if (sel) begin
          pend_v <= 1'b1;
          pend_d <= new_byte;
          pend_a <= ptr;
          if (ptr < LAST_REG) ptr <= ptr + 3'd1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q     <= '0;
      armed      <= 1'b0;
      center_lvl <= CENTER_DEF;
      gain_lvl   <= GAIN_DEF;
      bright_lvl <= '0;
      vcom_lvl   <= '0;
      pre_a_lvl  <= '0;
      pre_b_lvl  <= '0;
    end else begin
      if (commit && pend_a == 3'd0) begin
        mode_q <= pend_d;
        if (mode_q[7] && !pend_d[7]) armed <= 1'b1;
      end
      if (mode_q[7]) begin
        center_lvl <= CENTER_DEF;
        gain_lvl   <= GAIN_DEF;
        bright_lvl <= '0;
        vcom_lvl   <= '0;
        pre_a_lvl  <= '0;
        pre_b_lvl  <= '0;
      end else if (commit && armed) begin
        case (pend_a)
          3'd1: center_lvl <= pend_d[5:0];
          3'd2: gain_lvl   <= pend_d;
          3'd3: bright_lvl <= pend_d;
          3'd4: vcom_lvl   <= pend_d[6:0];
          3'd5: pre_a_lvl  <= pend_d[6:0];
          3'd6: pre_b_lvl  <= pend_d[6:0];
          default: ;
        endcase
      end
    end

  assign {soft_rst, pre_alt, line_inv, strobe_mode,
          scan_rev, pre_dual, pre_pol, clk_inv} = mode_q;

  wire at_defaults = center_lvl == CENTER_DEF && gain_lvl == GAIN_DEF &&
                     bright_lvl == 8'h00 && vcom_lvl == 7'h00 &&
                     pre_a_lvl == 7'h00 && pre_b_lvl == 7'h00;
  wire [42:0] lvl_all = {center_lvl, gain_lvl, bright_lvl, vcom_lvl, pre_a_lvl, pre_b_lvl};

  p_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && $past(soft_rst) |-> at_defaults);
  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> at_defaults);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_low |=> bit_cnt == 3'd0 && !have_des && !pend_v);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_low && $past(!en_low) && !soft_rst && !$past(soft_rst) |-> $stable(lvl_all));
  p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    have_des && $past(have_des) && $past(ptr) == LAST_REG |-> ptr == LAST_REG);
  p_chip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    have_des && !sel |-> !pend_v);
endmodule

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] strap_id = 3'd5;
  logic cfg_en_n = 1'b1, cfg_sck = 1'b0, cfg_sdi = 1'b0;
  logic [5:0] center_lvl;
  logic [7:0] gain_lvl, bright_lvl;
  logic [6:0] vcom_lvl, pre_a_lvl, pre_b_lvl;
  logic soft_rst, pre_alt, line_inv, strobe_mode, scan_rev, pre_dual, pre_pol, clk_inv;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_cfg_port i_serial_cfg_port (.*);

  function automatic logic [7:0] reg_val(input logic [2:0] idx);
    case (idx)
      3'd0: reg_val = {soft_rst, pre_alt, line_inv, strobe_mode, scan_rev, pre_dual, pre_pol, clk_inv};
      3'd1: reg_val = {2'b0, center_lvl};
      3'd2: reg_val = gain_lvl;
      3'd3: reg_val = bright_lvl;
      3'd4: reg_val = {1'b0, vcom_lvl};
      3'd5: reg_val = {1'b0, pre_a_lvl};
      default: reg_val = {1'b0, pre_b_lvl};
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] idx, input logic [7:0] exp);
    logic [7:0] act = reg_val(idx);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s reg%0d actual=%02h expected=%02h", req, idx, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b);
    cfg_sdi = b;
    repeat (4) @(negedge clk);
    cfg_sck = 1'b1;
    repeat (4) @(negedge clk);
    cfg_sck = 1'b0;
  endtask

  task automatic ser_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) ser_bit(b[i]);
  endtask

  task automatic xfer_open(input logic [2:0] chip, input logic [2:0] r);
    @(negedge clk);
    cfg_en_n = 1'b0;
    repeat (4) @(negedge clk);
    ser_byte({1'b0, chip, 1'b0, r});
  endtask

  task automatic xfer_close();
    repeat (4) @(negedge clk);
    cfg_en_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic write1(input logic [2:0] chip, input logic [2:0] r, input logic [7:0] d);
    xfer_open(chip, r);
    ser_byte(d);
    ser_byte(8'h00);
    xfer_close();
  endtask

  // {chip, start reg, data, checked reg, expected}
  localparam logic [24:0] VEC [9] = '{
    {3'd5, 3'd2, 8'h5A, 3'd2, 8'h5A},  // R2 R3 match, MSB first
    {3'd3, 3'd2, 8'h11, 3'd2, 8'h5A},  // R2 other chip ignored
    {3'd5, 3'd1, 8'hFF, 3'd1, 8'h3F},  // R5 centre 6 bits
    {3'd5, 3'd4, 8'h80, 3'd4, 8'h00},  // R5 common 7 bits
    {3'd5, 3'd3, 8'hC3, 3'd3, 8'hC3},
    {3'd5, 3'd6, 8'h7E, 3'd6, 8'h7E},
    {3'd5, 3'd5, 8'h01, 3'd5, 8'h01},
    {3'd5, 3'd7, 8'h99, 3'd6, 8'h7E},  // R10 register 7 ignored
    {3'd5, 3'd0, 8'h5A, 3'd0, 8'h5A}   // R6 mode bit order
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", 3'd0, 8'h00); check("R1", 3'd1, 8'h20); check("R1", 3'd2, 8'hBF);
    check("R1", 3'd3, 8'h00); check("R1", 3'd6, 8'h00);

    // R7 level writes refused before soft reset sequence
    write1(3'd5, 3'd2, 8'h12);
    check("R7", 3'd2, 8'hBF);
    write1(3'd5, 3'd0, 8'h80);
    check("R6", 3'd0, 8'h80);
    write1(3'd5, 3'd0, 8'h00);
    write1(3'd5, 3'd2, 8'h12);
    check("R7", 3'd2, 8'h12);

    for (int i = 0; i < 9; i++) begin
      write1(VEC[i][24:22], VEC[i][21:19], VEC[i][18:11]);
      check("VEC", VEC[i][10:8], VEC[i][7:0]);
    end

    // R3 no trailing byte: nothing committed
    xfer_open(3'd5, 3'd3);
    ser_byte(8'h66);
    xfer_close();
    check("R3", 3'd3, 8'hC3);

    // R4 auto-increment
    xfer_open(3'd5, 3'd1);
    ser_byte(8'h10); ser_byte(8'h20); ser_byte(8'h30); ser_byte(8'h00);
    xfer_close();
    check("R4", 3'd1, 8'h10); check("R4", 3'd2, 8'h20); check("R4", 3'd3, 8'h30);

    // R10 index stops at 6
    xfer_open(3'd5, 3'd5);
    ser_byte(8'h11); ser_byte(8'h22); ser_byte(8'h33); ser_byte(8'h00);
    xfer_close();
    check("R10", 3'd5, 8'h11); check("R10", 3'd6, 8'h33);

    // R9 abort mid byte, then a fresh transfer
    xfer_open(3'd5, 3'd3);
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
    xfer_close();
    check("R9", 3'd3, 8'h30);
    write1(3'd5, 3'd3, 8'h44);
    check("R9", 3'd3, 8'h44);

    // R11 clocks with enable high
    for (int i = 0; i < 24; i++) ser_bit(i[0]);
    repeat (8) @(negedge clk);
    check("R11", 3'd3, 8'h44); check("R11", 3'd2, 8'h20);

    // R8 soft reset restores and holds defaults
    write1(3'd5, 3'd0, 8'h81);
    check("R8", 3'd2, 8'hBF); check("R8", 3'd3, 8'h00); check("R8", 3'd1, 8'h20);
    write1(3'd5, 3'd2, 8'h55);
    check("R8", 3'd2, 8'hBF);
    write1(3'd5, 3'd0, 8'h24);
    check("R6", 3'd0, 8'h24);
    write1(3'd5, 3'd2, 8'h55);
    check("R8", 3'd2, 8'h55);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule